// File: doc/BRIEF.md
# Processor Reset Pulse and Watchdog Timer

This block holds a processor in reset while supply power is not good. Once power is good it stretches the reset pulse over a fixed number of timing ticks, and after that it supervises a watchdog strobe. Time is measured only in ticks: one-cycle pulses on `tick_i`. The pulses come either from an external clock or from a fixed 1 ms internal timebase. A two-bit mode input picks one of three timing sets.

After reset releases, the watchdog first allows a long period. The first level change on the strobe switches it to the normal period. Every later level change restarts the count. If the count expires, the block raises a fault and drives reset again for one full reset pulse. It then starts over with the long period.

The sequencer has five states:
- `ST_PWR_LOW`: power is bad; reset is held and the counter is cleared.
- `ST_RST_HOLD`: the power-on reset pulse is being timed.
- `ST_WD_RST`: the reset pulse after a watchdog fault is being timed, with the fault flag set.
- `ST_WD_FIRST`: the watchdog is running with the long first period.
- `ST_WD_NORM`: the watchdog is running with the normal period.

The transitions are:
- power lost: any state goes to `ST_PWR_LOW`.
- power restored: `ST_PWR_LOW` goes to `ST_RST_HOLD`.
- pulse done: `ST_RST_HOLD` or `ST_WD_RST` goes to `ST_WD_FIRST`.
- first strobe: `ST_WD_FIRST` goes to `ST_WD_NORM`.
- timeout: `ST_WD_FIRST` or `ST_WD_NORM` goes to `ST_WD_RST`.

Top module: `wdt_reset_timer`

## Requirements
- R1: While `rst_n` is low, `reset_o` is 1 and `wdt_fault_o` is 0.
- R2: When `pwr_good_i` is sampled low at a clock edge, `reset_o` is 1 and `wdt_fault_o` is 0 from that edge on, and the tick count restarts from zero. This holds even if a fault was showing.
- R3: After `pwr_good_i` is sampled high, `reset_o` falls on the clock edge that samples the Nth tick, where N is the reset length of the current mode. Cycles without a tick do not count.
- R4: After reset falls, the watchdog uses the long first period until the first strobe edge. A timeout asserts reset on the edge that samples the last tick of that period.
- R5: In the watchdog states, any level change on `wdi_i`, rising or falling, restarts the count. The first such change selects the normal period.
- R6: On a timeout, `reset_o` and `wdt_fault_o` both rise. They stay high for the reset length in ticks, then fall together. The watchdog then restarts with the long first period.
- R7: The mode table is as follows (tick counts for reset / first period / normal period):
  - `mode_i`=00, external clock: 2048 / 4096 / 1024.
  - `mode_i`=01, internal short: 200 / 1600 / 100.
  - `mode_i`=10 or 11, internal long: 200 / 1600 / 1600.
  All lengths are parameters.
- R8: If a strobe edge and a tick are sampled in the same cycle, the edge wins. The count restarts and that tick is not counted.
- R9: Strobe edges while reset is asserted have no effect on the reset pulse length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| mode_i | input | 2 | Timing set select (see R7) |
| tick_i | input | 1 | One-cycle timing tick (external clock edge or 1 ms timebase) |
| pwr_good_i | input | 1 | Supply good indication; low forces reset |
| wdi_i | input | 1 | Watchdog strobe; any level change restarts the count |
| reset_o | output | 1 | Processor reset, active high |
| wdt_fault_o | output | 1 | High during a reset pulse caused by a watchdog timeout |

## Verification
The hardest situation to reach is a timeout from the normal period that lands exactly on the cycle where a strobe edge also arrives. Reaching it takes a full power-up pulse and a first-period strobe. It also needs exact tick counting up to one tick before expiry.

Directed sequences walk through each state with counted ticks, including a coincident tick and edge and a power drop while the fault is showing. They also change mode between power cycles. A long constrained-random run then toggles the strobe at a rate close to the normal period, so timeouts and narrow escapes both occur. That run also drops power briefly and changes mode at any moment, including mid-count, and compares against a bench model every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        ST_PWR_LOW  = 3'd0,
        ST_RST_HOLD = 3'd1,
        ST_WD_RST   = 3'd2,
        ST_WD_FIRST = 3'd3,
        ST_WD_NORM  = 3'd4
    } wdt_state_e;

    typedef enum logic [1:0] {
        LEN_RESET = 2'd0,
        LEN_FIRST = 2'd1,
        LEN_NORM  = 2'd2
    } wdt_len_sel_e;

    function automatic int wdt_max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdt_mode_decode.sv
module wdt_mode_decode #(
    parameter int CNT_W        = 13,
    parameter int EXT_RST      = 2048,
    parameter int EXT_WD_FIRST = 4096,
    parameter int EXT_WD_NORM  = 1024,
    parameter int INT_RST      = 200,
    parameter int INT_WD_SHORT = 100,
    parameter int INT_WD_LONG  = 1600
) (
    input  logic [1:0]       mode_i,
    input  wdt_pkg::wdt_len_sel_e len_sel_i,
    output logic [CNT_W-1:0] len_o
);
    logic [CNT_W-1:0] rst_len;
    logic [CNT_W-1:0] first_len;
    logic [CNT_W-1:0] norm_len;

    always_comb begin
        unique case (mode_i)
            2'b00: begin
                rst_len   = CNT_W'(EXT_RST);
                first_len = CNT_W'(EXT_WD_FIRST);
                norm_len  = CNT_W'(EXT_WD_NORM);
            end
            2'b01: begin
                rst_len   = CNT_W'(INT_RST);
                first_len = CNT_W'(INT_WD_LONG);
                norm_len  = CNT_W'(INT_WD_SHORT);
            end
            default: begin
                rst_len   = CNT_W'(INT_RST);
                first_len = CNT_W'(INT_WD_LONG);
                norm_len  = CNT_W'(INT_WD_LONG);
            end
        endcase
    end

    always_comb begin
        unique case (len_sel_i)
            wdt_pkg::LEN_FIRST: len_o = first_len;
            wdt_pkg::LEN_NORM:  len_o = norm_len;
            default:            len_o = rst_len;
        endcase
    end
endmodule

// File: rtl/wdt_edge_detect.sv
module wdt_edge_detect #(
    parameter int SYNC_STAGES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic edge_o
);
    logic lvl_s;
    logic prev_q;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] sh_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh_q <= '0;
                end else begin
                    sh_q[0] <= lvl_i;
                    for (int i = 1; i < SYNC_STAGES; i++) begin
                        sh_q[i] <= sh_q[i-1];
                    end
                end
            end
            assign lvl_s = sh_q[SYNC_STAGES-1];
        end else begin : g_raw
            assign lvl_s = lvl_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_s;
    end

    assign edge_o = lvl_s ^ prev_q;
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign hit_o   = tick_i && (cnt_inc >= {1'b0, len_i});
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_inc[CNT_W-1:0];
    end
endmodule

// File: rtl/wdt_seq_fsm.sv
module wdt_seq_fsm #(
    parameter int CNT_W = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_good_i,
    input  logic                  tick_i,
    input  logic                  wdi_edge_i,
    input  logic                  hit_i,
    input  logic [CNT_W-1:0]      cnt_i,
    output logic                  reset_o,
    output logic                  fault_o,
    output logic                  cnt_clr_o,
    output wdt_pkg::wdt_len_sel_e len_sel_o
);
    import wdt_pkg::*;

    wdt_state_e state_q, state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWR_LOW;
        else        state_q <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_PWR_LOW:  state_nxt = ST_RST_HOLD;
            ST_RST_HOLD,
            ST_WD_RST:   if (hit_i) state_nxt = ST_WD_FIRST;
            ST_WD_FIRST: begin
                if (wdi_edge_i)  state_nxt = ST_WD_NORM;
                else if (hit_i)  state_nxt = ST_WD_RST;
            end
            ST_WD_NORM:  if (!wdi_edge_i && hit_i) state_nxt = ST_WD_RST;
            default:     state_nxt = ST_PWR_LOW;
        endcase
        if (!pwr_good_i) state_nxt = ST_PWR_LOW;
    end

    // outputs
    always_comb begin
        reset_o   = 1'b0;
        fault_o   = 1'b0;
        len_sel_o = LEN_RESET;
        unique case (state_q)
            ST_PWR_LOW:  reset_o = 1'b1;
            ST_RST_HOLD: reset_o = 1'b1;
            ST_WD_RST: begin
                reset_o = 1'b1;
                fault_o = 1'b1;
            end
            ST_WD_FIRST: len_sel_o = LEN_FIRST;
            ST_WD_NORM:  len_sel_o = LEN_NORM;
            default:     reset_o = 1'b1;
        endcase
        cnt_clr_o = (state_nxt != state_q) || (state_q == ST_PWR_LOW)
                  || ((state_q == ST_WD_NORM) && wdi_edge_i);
    end

    // R6: a fault is only ever shown with reset asserted
    a_r6_fault_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> reset_o);

    // R2: power loss forces the power-low state at the next edge
    a_r2_power_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_i |=> (reset_o && !fault_o && cnt_i == '0));

    // R5: a strobe edge while watching restarts the count and keeps reset low
    a_r5_edge_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good_i && wdi_edge_i && !reset_o) |=> (cnt_i == '0 && !reset_o));

    // R3: reset cannot end on a cycle without a tick
    a_r3_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_o && !tick_i) |=> reset_o);

    // R6: a fault only starts from a watchdog state
    a_r6_fault_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> ($past(state_q) == ST_WD_FIRST || $past(state_q) == ST_WD_NORM));

    // R4: reset always releases into the long first period
    a_r4_first_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_o) |-> (state_q == ST_WD_FIRST));
endmodule

// File: rtl/wdt_reset_timer.sv
module wdt_reset_timer #(
    parameter int EXT_RST      = 2048,
    parameter int EXT_WD_FIRST = 4096,
    parameter int EXT_WD_NORM  = 1024,
    parameter int INT_RST      = 200,
    parameter int INT_WD_SHORT = 100,
    parameter int INT_WD_LONG  = 1600,
    parameter int SYNC_STAGES  = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       tick_i,
    input  logic       pwr_good_i,
    input  logic       wdi_i,
    output logic       reset_o,
    output logic       wdt_fault_o
);
    import wdt_pkg::*;

    localparam int LEN_MAX = wdt_max2(wdt_max2(wdt_max2(EXT_RST, EXT_WD_FIRST), EXT_WD_NORM),
                                      wdt_max2(wdt_max2(INT_RST, INT_WD_SHORT), INT_WD_LONG));
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    logic             wdi_edge;
    logic             hit;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len;
    wdt_len_sel_e     len_sel;

    wdt_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (wdi_i),
        .edge_o (wdi_edge)
    );

    wdt_mode_decode #(
        .CNT_W        (CNT_W),
        .EXT_RST      (EXT_RST),
        .EXT_WD_FIRST (EXT_WD_FIRST),
        .EXT_WD_NORM  (EXT_WD_NORM),
        .INT_RST      (INT_RST),
        .INT_WD_SHORT (INT_WD_SHORT),
        .INT_WD_LONG  (INT_WD_LONG)
    ) u_dec (
        .mode_i    (mode_i),
        .len_sel_i (len_sel),
        .len_o     (len)
    );

    wdt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .tick_i (tick_i),
        .len_i  (len),
        .hit_o  (hit),
        .cnt_o  (cnt)
    );

    wdt_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good_i (pwr_good_i),
        .tick_i     (tick_i),
        .wdi_edge_i (wdi_edge),
        .hit_i      (hit),
        .cnt_i      (cnt),
        .reset_o    (reset_o),
        .fault_o    (wdt_fault_o),
        .cnt_clr_o  (cnt_clr),
        .len_sel_o  (len_sel)
    );
endmodule

// File: tb/sim_wdt_reset_timer.sv
module sim_wdt_reset_timer;
    localparam int CLK_PERIOD = 10;
    localparam int ER = 16;
    localparam int EF = 32;
    localparam int EN = 8;
    localparam int IR = 10;
    localparam int IS = 5;
    localparam int IL = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       tick_i = 1'b0;
    logic       pwr_good_i = 1'b0;
    logic       wdi_i = 1'b0;
    logic       reset_o;
    logic       wdt_fault_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic w_lvl = 1'b0;

    // bench model: 0 power low, 1 reset hold, 2 fault reset, 3 first, 4 normal
    int   m_st = 0;
    int   m_cnt = 0;
    logic m_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_reset_timer #(
        .EXT_RST(ER), .EXT_WD_FIRST(EF), .EXT_WD_NORM(EN),
        .INT_RST(IR), .INT_WD_SHORT(IS), .INT_WD_LONG(IL), .SYNC_STAGES(0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .tick_i(tick_i),
        .pwr_good_i(pwr_good_i), .wdi_i(wdi_i),
        .reset_o(reset_o), .wdt_fault_o(wdt_fault_o)
    );

    // R7 table: which 0 reset, 1 first period, 2 normal period
    function automatic int exp_len(input logic [1:0] md, input int which);
        if (md == 2'b00) return (which == 0) ? ER : (which == 1) ? EF : EN;
        if (md == 2'b01) return (which == 0) ? IR : (which == 1) ? IL : IS;
        return (which == 0) ? IR : IL;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic t, input logic w);
        logic e;
        int   lim;
        e = (w != m_prev);
        m_prev = w;
        if (!pwr_good_i) begin
            m_st = 0; m_cnt = 0;
        end else begin
            case (m_st)
                0: begin m_st = 1; m_cnt = 0; end
                1, 2: begin
                    lim = exp_len(mode_i, 0);
                    if (t) begin
                        if (m_cnt + 1 >= lim) begin m_st = 3; m_cnt = 0; end
                        else m_cnt++;
                    end
                end
                3: begin
                    lim = exp_len(mode_i, 1);
                    if (e) begin m_st = 4; m_cnt = 0; end
                    else if (t) begin
                        if (m_cnt + 1 >= lim) begin m_st = 2; m_cnt = 0; end
                        else m_cnt++;
                    end
                end
                default: begin
                    lim = exp_len(mode_i, 2);
                    if (e) m_cnt = 0;
                    else if (t) begin
                        if (m_cnt + 1 >= lim) begin m_st = 2; m_cnt = 0; end
                        else m_cnt++;
                    end
                end
            endcase
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic drive(input logic t, input logic w);
        tick_i = t;
        wdi_i  = w;
        model_step(t, w);
        @(negedge clk);
        chk("model reset", reset_o, (m_st <= 2));
        chk("model fault", wdt_fault_o, (m_st == 2));
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            drive(1'b1, w_lvl);
            drive(1'b0, w_lvl);
        end
    endtask

    task automatic toggle();
        w_lvl = ~w_lvl;
        drive(1'b0, w_lvl);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R1 reset in block reset", reset_o, 1'b1);
        chk("R1 fault in block reset", wdt_fault_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: power low holds reset regardless of ticks
        tick_n(40);
        chk("R2 reset while power low", reset_o, 1'b1);

        // R3 / R9: power good, count reset with gaps and strobe edges
        pwr_good_i = 1'b1;
        drive(1'b0, w_lvl);
        for (int i = 0; i < ER - 1; i++) begin
            drive(1'b1, w_lvl);
            drive(1'b0, w_lvl);
            if (i % 3 == 0) toggle();
        end
        chk("R9 reset held despite edges", reset_o, 1'b1);
        chk("R3 reset before last tick", reset_o, 1'b1);
        tick_n(1);
        chk("R3 reset released on last tick", reset_o, 1'b0);

        // R4: first period is long
        tick_n(EN);
        chk("R4 no timeout at normal length", reset_o, 1'b0);
        tick_n(EF - 1 - EN);
        chk("R4 no timeout before first length", reset_o, 1'b0);
        tick_n(1);
        chk("R4 timeout at first length", reset_o, 1'b1);
        chk("R6 fault on timeout", wdt_fault_o, 1'b1);

        // R6: fault reset pulse
        tick_n(ER - 1);
        chk("R6 fault held", wdt_fault_o, 1'b1);
        tick_n(1);
        chk("R6 reset ends", reset_o, 1'b0);
        chk("R6 fault ends", wdt_fault_o, 1'b0);

        // R5: edges restart, normal period after first edge
        toggle();
        tick_n(EN - 1);
        chk("R5 normal period not yet", reset_o, 1'b0);
        toggle();
        tick_n(EN - 1);
        chk("R5 restart by falling or rising edge", reset_o, 1'b0);
        tick_n(1);
        chk("R5 timeout at normal length", wdt_fault_o, 1'b1);

        // R2: power drop clears a showing fault
        pwr_good_i = 1'b0;
        drive(1'b0, w_lvl);
        chk("R2 fault cleared by power loss", wdt_fault_o, 1'b0);
        chk("R2 reset on power loss", reset_o, 1'b1);
        pwr_good_i = 1'b1;
        drive(1'b0, w_lvl);
        tick_n(ER);
        chk("R3 reset released after power restore", reset_o, 1'b0);

        // R8: edge and tick together, edge wins
        toggle();
        tick_n(EN - 1);
        w_lvl = ~w_lvl;
        drive(1'b1, w_lvl);
        drive(1'b0, w_lvl);
        tick_n(EN - 1);
        chk("R8 coincident tick not counted", reset_o, 1'b0);
        tick_n(1);
        chk("R8 timeout after restart", reset_o, 1'b1);

        // R7: internal short mode
        pwr_good_i = 1'b0;
        mode_i = 2'b01;
        drive(1'b0, w_lvl);
        pwr_good_i = 1'b1;
        drive(1'b0, w_lvl);
        tick_n(IR - 1);
        chk("R7 short mode reset held", reset_o, 1'b1);
        tick_n(1);
        chk("R7 short mode reset length", reset_o, 1'b0);
        tick_n(IL - 1);
        chk("R7 short mode first period held", reset_o, 1'b0);
        tick_n(1);
        chk("R7 short mode first period", wdt_fault_o, 1'b1);
        tick_n(IR);
        toggle();
        tick_n(IS - 1);
        chk("R7 short mode normal held", reset_o, 1'b0);
        tick_n(1);
        chk("R7 short mode normal period", wdt_fault_o, 1'b1);

        // R7: internal long mode, normal equals first
        mode_i = 2'b10;
        tick_n(IR);
        toggle();
        tick_n(IL - 1);
        chk("R7 long mode normal held", reset_o, 1'b0);
        tick_n(1);
        chk("R7 long mode normal period", wdt_fault_o, 1'b1);

        // constrained random against the model
        for (int i = 0; i < 15000; i++) begin
            logic t;
            t = 1'($urandom % 2);
            if ($urandom % 14 == 0) w_lvl = ~w_lvl;
            if (pwr_good_i && ($urandom % 600 == 0)) pwr_good_i = 1'b0;
            else if (!pwr_good_i && ($urandom % 4 == 0)) pwr_good_i = 1'b1;
            if ($urandom % 900 == 0) mode_i = 2'($urandom % 4);
            drive(t, w_lvl);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule